// File: doc/BRIEF.md
# Timing Calibration Loop Supervisor

This block supervises one timing-calibration loop. All of its decisions fall on a slow control tick, which is derived from the fast clock by a programmable power-of-two predivider. The whole design stays in the fast clock domain: the tick is a single-cycle enable pulse, not a second clock.

An external measurement unit offers candidate optimum settings over a valid/ready stream. The block takes at most one sample per tick. It can smooth the samples with a four-deep running mean. It then compares the distance between that optimum and the current setting against a programmed threshold. What happens next depends on the mode:

- **Manual:** the block measures only when software arms it, and the setting changes only when software writes it.
- **Surveillance:** the block records each new optimum. If the error is too large, it raises an interrupt and stops.
- **Auto:** if the error is too large, the block loads the new optimum into the setting and keeps running.

A plain parallel register port gives software its configuration and status. This port stands in for a serial register file.

Back-pressure rules on the measurement stream:

- The producer holds `meas_valid` and `meas_opt` steady until it sees `meas_ready` high at a rising edge. That edge is the transfer.
- `meas_ready` does not depend on `meas_valid`.
- `meas_ready` is high for exactly one fast cycle per tick, and only while the loop is willing to take a sample.

Register map (`reg_addr`):

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | CTRL | read/write | [1:0] mode (00 manual, 01 surveillance, 10 auto); [2] average enable; [3] interrupt enable |
| 1 | THRESH | read/write | error threshold |
| 2 | PREDIV | read/write | [3:0] predivide code |
| 3 | SETTING | read/write | the current setting |
| 4 | STATUS | read only | [0] interrupt pending; [1] halted |
| 5 | RESULT | read only | the last evaluated optimum |
| 6 | ARM | write only | writing 1 to bit 0 arms one manual measurement |

Top module: `tcl_supervisor`

## Requirements
- R1: The tick period is 2^(PREDIV[3:0]+4) fast cycles, seen as the spacing between `meas_ready` pulses. A write to PREDIV restarts the count, so the first pulse after the write comes 2^(code+4)-1 cycles after the cycle that follows the write edge.
- R2: A sample transfers only on a cycle with both `meas_valid` and `meas_ready` high, and `meas_ready` is high for at most one cycle per tick.
- R3: In manual mode, `meas_ready` stays low unless a write of 1 to ARM bit 0 has armed one measurement. That measurement updates RESULT and leaves the setting alone. The setting changes only through SETTING writes, and a SETTING write in any other mode is ignored. A mode code of 11 is stored and read back as 00.
- R4: In surveillance mode, RESULT takes each evaluated optimum. The error is |optimum − setting|, taken as unsigned 8-bit. An error strictly greater than THRESH sets STATUS bit 0 and STATUS bit 1 (halted). An equal error does not. While halted, `meas_ready` stays low.
- R5: In auto mode, an error strictly greater than THRESH loads the optimum into the setting, and the loop keeps accepting samples. No interrupt is ever raised in this mode.
- R6: With CTRL bit 2 set, the evaluated optimum is floor(sum of the last four accepted samples / 4). The first sample after reset, or after any CTRL write that changes the mode, fills all four slots. With CTRL bit 2 clear, the optimum is the raw sample.
- R7: `irq` equals STATUS bit 0 AND CTRL bit 3.
- R8: A pending interrupt clears only at a tick that ends a full tick period during which CTRL bit 3 was low throughout. A shorter low pulse leaves it pending. Clearing it also clears halted.
- R9: Any CTRL write clears halted, which restarts the loop, and leaves STATUS bit 0 as it was.
- R10: After reset the registers read CTRL=0x00, THRESH=0x10, PREDIV=0x0F, SETTING=0x80 and STATUS=0x00, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock |
| rst_n | input | 1 | active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register address for both read and write |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | register read data, combinational from `reg_addr` |
| meas_valid | input | 1 | a measurement sample is offered |
| meas_ready | output | 1 | the block takes the sample at this edge |
| meas_opt | input | 8 | the optimum setting that was measured |
| setting | output | 8 | the current setting driven to the delay line |
| irq_pending | output | 1 | interrupt status flag |
| irq | output | 1 | interrupt request, gated by the enable |

## Verification
The assertions take three things for granted about the inputs:

- A write to PREDIV happens together with a counter restart, so the count can never sit above its new limit.
- The tick period is at least two cycles.
- A sample is evaluated before the next tick can start another one.

The bench keeps within these limits. It drives inputs only at falling edges and holds `meas_valid` until a transfer. It runs the sweeps at the shortest tick of 16 cycles, and it waits several cycles after each transfer before it reads a register.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  typedef enum logic [1:0] {
    MODE_MANUAL = 2'b00,
    MODE_WATCH  = 2'b01,
    MODE_AUTO   = 2'b10,
    MODE_RSVD   = 2'b11
  } loop_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_THRESH  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PREDIV  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SETTING = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RESULT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ARM     = 3'd6;
endpackage

// File: rtl/tcl_prediv.sv
module tcl_prediv #(
  parameter int CODE_W     = 4,
  parameter int BASE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              tick
);
  localparam int CNT_W = BASE_SHIFT + (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = {CNT_W{1'b1}} >> (CNT_W - BASE_SHIFT - 32'(code));
  assign tick = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);
endmodule

// File: rtl/tcl_avg.sv
module tcl_avg #(
  parameter int W     = 8,
  parameter int DEPTH_LOG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] raw,
  output logic [W-1:0] mean
);
  localparam int DEPTH = 1 << DEPTH_LOG;
  localparam int SW    = W + DEPTH_LOG;

  logic [W-1:0]  hist [DEPTH];
  logic          primed;
  logic [SW-1:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (push) begin
      primed <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (!primed || flush || i == 0) hist[i] <= din;
        else                            hist[i] <= hist[i-1];
      end
    end else if (flush) begin
      primed <= 1'b0;
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < DEPTH; i++) sum = sum + SW'(hist[i]);
  end

  assign mean = sum[SW-1:DEPTH_LOG];
  assign raw  = hist[0];

  assert_fill_on_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (!primed || flush)) |=> (mean == $past(din)));
endmodule

// File: rtl/tcl_policy.sv
module tcl_policy
  import tcl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  loop_mode_e   mode,
  input  logic         irq_en,
  input  logic [W-1:0] thresh,
  input  logic         eval,
  input  logic [W-1:0] opt,
  input  logic         man_wr,
  input  logic [W-1:0] man_val,
  input  logic         ctrl_wr,
  input  logic [W-1:0] set_init,
  output logic [W-1:0] setting,
  output logic [W-1:0] result,
  output logic         pending,
  output logic         halted
);
  logic [W-1:0] err;
  logic         over;
  logic         trip;
  logic         en_seen;
  logic         clr;

  assign err  = (opt >= setting) ? (opt - setting) : (setting - opt);
  assign over = err > thresh;
  assign trip = eval && over && (mode == MODE_WATCH);
  assign clr  = tick && !en_seen && !irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting <= set_init;
      result  <= '0;
    end else begin
      if (man_wr && mode == MODE_MANUAL)
        setting <= man_val;
      else if (eval && over && mode == MODE_AUTO)
        setting <= opt;
      if (eval) result <= opt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen <= 1'b0;
    else if (tick) en_seen <= irq_en;
    else en_seen <= en_seen | irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      halted  <= 1'b0;
    end else begin
      if (trip)     pending <= 1'b1;
      else if (clr) pending <= 1'b0;
      if (trip)                halted <= 1'b1;
      else if (clr || ctrl_wr) halted <= 1'b0;
    end
  end

  assert_pending_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(mode == MODE_WATCH));
  assert_setting_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_wr && !eval) |=> $stable(setting));
  assert_clear_needs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> !$past(irq_en));
endmodule

// File: rtl/tcl_supervisor.sv
module tcl_supervisor
  import tcl_pkg::*;
#(
  parameter int          W          = 8,
  parameter int          CODE_W     = 4,
  parameter int          BASE_SHIFT = 4,
  parameter int          AVG_LOG    = 2,
  parameter logic [7:0]  THR_INIT   = 8'h10,
  parameter logic [7:0]  SET_INIT   = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              meas_valid,
  output logic              meas_ready,
  input  logic [W-1:0]      meas_opt,
  output logic [W-1:0]      setting,
  output logic              irq_pending,
  output logic              irq
);
  loop_mode_e        mode;
  loop_mode_e        new_mode;
  logic              avg_en;
  logic              irq_en;
  logic [W-1:0]      thresh;
  logic [CODE_W-1:0] pcode;
  logic              armed;
  logic              eval_q;
  logic              tick;
  logic              halted;
  logic              take;
  logic              ctrl_wr;
  logic              mode_chg;
  logic [W-1:0]      raw;
  logic [W-1:0]      mean;
  logic [W-1:0]      result;

  assign ctrl_wr  = reg_wr && reg_addr == A_CTRL;
  assign new_mode = (loop_mode_e'(reg_wdata[1:0]) == MODE_RSVD) ? MODE_MANUAL
                                                                 : loop_mode_e'(reg_wdata[1:0]);
  assign mode_chg = ctrl_wr && (new_mode != mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_MANUAL;
      avg_en <= 1'b0;
      irq_en <= 1'b0;
      thresh <= THR_INIT;
      pcode  <= '1;
      armed  <= 1'b0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= take;
      if (ctrl_wr) begin
        mode   <= new_mode;
        avg_en <= reg_wdata[2];
        irq_en <= reg_wdata[3];
      end
      if (reg_wr && reg_addr == A_THRESH) thresh <= reg_wdata;
      if (reg_wr && reg_addr == A_PREDIV) pcode <= reg_wdata[CODE_W-1:0];
      if (mode_chg || take)                       armed <= 1'b0;
      else if (reg_wr && reg_addr == A_ARM && reg_wdata[0]) armed <= 1'b1;
    end
  end

  assign meas_ready = tick && ((mode == MODE_MANUAL) ? armed : !halted);
  assign take       = meas_valid && meas_ready;

  tcl_prediv #(.CODE_W(CODE_W), .BASE_SHIFT(BASE_SHIFT)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (pcode),
    .restart (reg_wr && reg_addr == A_PREDIV),
    .tick    (tick)
  );

  tcl_avg #(.W(W), .DEPTH_LOG(AVG_LOG)) u_avg (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (mode_chg),
    .push  (take),
    .din   (meas_opt),
    .raw   (raw),
    .mean  (mean)
  );

  tcl_policy #(.W(W)) u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .irq_en   (irq_en),
    .thresh   (thresh),
    .eval     (eval_q),
    .opt      (avg_en ? mean : raw),
    .man_wr   (reg_wr && reg_addr == A_SETTING),
    .man_val  (reg_wdata),
    .ctrl_wr  (ctrl_wr),
    .set_init (SET_INIT),
    .setting  (setting),
    .result   (result),
    .pending  (irq_pending),
    .halted   (halted)
  );

  assign irq = irq_pending && irq_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:    reg_rdata = W'({irq_en, avg_en, mode});
      A_THRESH:  reg_rdata = thresh;
      A_PREDIV:  reg_rdata = W'(pcode);
      A_SETTING: reg_rdata = setting;
      A_STATUS:  reg_rdata = W'({halted, irq_pending});
      A_RESULT:  reg_rdata = result;
      default:   reg_rdata = '0;
    endcase
  end

  assert_ready_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ready |-> tick);
  assert_eval_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eval_q |=> !eval_q);
endmodule

// File: tb/tb_tcl_supervisor.sv
module tb_tcl_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       meas_valid = 1'b0;
  logic       meas_ready;
  logic [7:0] meas_opt = '0;
  logic [7:0] setting;
  logic       irq_pending;
  logic       irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tcl_supervisor dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .meas_valid(meas_valid),
    .meas_ready(meas_ready), .meas_opt(meas_opt), .setting(setting),
    .irq_pending(irq_pending), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #0.5;
    v = int'(reg_rdata);
  endtask

  task automatic push(input logic [7:0] v, input int maxwait, output bit ok);
    int k;
    @(negedge clk);
    meas_valid = 1'b1; meas_opt = v;
    k = 0;
    while (!meas_ready && k < maxwait) begin
      @(negedge clk);
      k++;
    end
    ok = meas_ready;
    @(negedge clk);
    meas_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  initial begin
    int v;
    int exp_set;
    bit ok;
    int win[4];
    bit primed;
    int sum;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(3'd0, v); check("R10 ctrl", v, 8'h00);
    rd(3'd1, v); check("R10 thresh", v, 8'h10);
    rd(3'd2, v); check("R10 prediv", v, 8'h0F);
    rd(3'd3, v); check("R10 setting", v, 8'h80);
    rd(3'd4, v); check("R10 status", v, 0);
    check("R10 irq", int'(irq), 0);

    // R3 reserved mode code reads back as manual
    wr(3'd0, 8'h03);
    rd(3'd0, v); check("R3 mode 11 stored as 00", v & 3, 0);

    // R1 predivider sweep
    wr(3'd0, 8'h02);
    for (int c = 0; c < 4; c++) begin
      int k;
      int n;
      n = 1 << (c + 4);
      wr(3'd2, 8'(c));
      k = 0;
      while (!meas_ready && k < 1000) begin @(negedge clk); k++; end
      check("R1 first tick after prediv write", k, n - 1);
      k = 0;
      do begin @(negedge clk); k++; end while (!meas_ready && k < 1000);
      check("R1 tick period", k, n);
      @(negedge clk);
      check("R2 ready one cycle", int'(meas_ready), 0);
    end
    wr(3'd2, 8'h00);

    // R3 manual mode
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h80);
    push(8'h33, 60, ok); check("R3 unarmed no transfer", int'(ok), 0);
    wr(3'd6, 8'h01);
    push(8'h33, 60, ok); check("R3 armed transfer", int'(ok), 1);
    rd(3'd5, v); check("R3 result updated", v, 8'h33);
    check("R3 setting untouched", int'(setting), 8'h80);
    push(8'h44, 60, ok); check("R3 one transfer per arm", int'(ok), 0);
    wr(3'd3, 8'h5A);
    check("R3 setting write manual", int'(setting), 8'h5A);
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h11);
    check("R3 setting write ignored in auto", int'(setting), 8'h5A);

    // R5 auto sweep with threshold boundary
    for (int ti = 0; ti < 3; ti++) begin
      int t;
      t = (ti == 0) ? 0 : (ti == 1) ? 7 : 64;
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h40);
      wr(3'd1, 8'(t));
      wr(3'd0, 8'h02);
      exp_set = 8'h40;
      push(8'(8'h40 + t), 60, ok);
      check("R5 equal error no load", int'(setting), exp_set);
      push(8'(8'h40 + t + 1), 60, ok);
      exp_set = 8'h40 + t + 1;
      check("R5 above threshold loads", int'(setting), exp_set);
      for (int i = 0; i < 16; i++) begin
        int s;
        s = (i * 37 + 11) & 255;
        push(8'(s), 60, ok);
        check("R2 auto transfer", int'(ok), 1);
        if (absd(s, exp_set) > t) exp_set = s;
        check("R5 auto setting", int'(setting), exp_set);
        check("R5 no irq in auto", int'(irq_pending), 0);
      end
    end

    // R4, R7, R8, R9 surveillance sweep
    wr(3'd1, 8'd16);
    for (int i = 0; i < 7; i++) begin
      int s;
      bit trip;
      case (i)
        0: s = 8'h80; 1: s = 8'h90; 2: s = 8'h91; 3: s = 8'h6F;
        4: s = 8'h70; 5: s = 8'h00; default: s = 8'hFF;
      endcase
      trip = absd(s, 8'h80) > 16;
      wr(3'd0, 8'h08);
      wr(3'd3, 8'h80);
      wr(3'd0, 8'h09);
      push(8'(s), 60, ok);
      rd(3'd5, v); check("R4 result tracks optimum", v, s);
      check("R4 setting kept", int'(setting), 8'h80);
      rd(3'd4, v); check("R4 status", v, trip ? 3 : 0);
      check("R7 irq with enable", int'(irq), int'(trip));
      if (trip) begin
        push(8'h80, 60, ok); check("R4 halted blocks ready", int'(ok), 0);
        if (i == 2) begin
          wr(3'd0, 8'h01);
          wr(3'd0, 8'h09);
          repeat (40) @(negedge clk);
          rd(3'd4, v); check("R8 short low keeps pending", v & 1, 1);
        end
        wr(3'd0, 8'h01);
        check("R7 irq masked", int'(irq), 0);
        rd(3'd4, v); check("R9 ctrl write restarts keeps pending", v, 1);
        repeat (40) @(negedge clk);
        rd(3'd4, v); check("R8 full low period clears", v, 0);
      end
    end

    // R6 averaging filter
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h06);
    primed = 0;
    for (int i = 0; i < 10; i++) begin
      int s;
      s = (i * 53 + 29) & 255;
      if (i == 6) begin
        wr(3'd0, 8'h0E);
      end
      if (i == 8) begin
        wr(3'd0, 8'h04);
        wr(3'd0, 8'h06);
        primed = 0;
      end
      push(8'(s), 60, ok);
      if (!primed) begin
        for (int j = 0; j < 4; j++) win[j] = s;
        primed = 1;
      end else begin
        for (int j = 3; j > 0; j--) win[j] = win[j-1];
        win[0] = s;
      end
      sum = win[0] + win[1] + win[2] + win[3];
      rd(3'd5, v); check("R6 running mean", v, sum >> 2);
    end
    wr(3'd0, 8'h02);
    push(8'h21, 60, ok);
    rd(3'd5, v); check("R6 raw when averaging off", v, 8'h21);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule